// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Error Status

This block receives asynchronous serial characters on a single line and delivers them as parallel bytes. The line is examined on a sampling enable that pulses 16 times per bit period. An idle-to-low transition starts a candidate character. Each bit is judged from four samples taken near its centre, and a start is only accepted when all four of those samples are low. The complete character is gathered in a 12-bit assembly register. The data byte then moves into an 8-bit hold register and from there into a receive queue. A read strobe drains the queue onto a registered parallel output.

A four-flag status word records parity mismatches, framing faults (a bad stop bit or a bit whose samples disagree), characters lost because the queue was full, and a line held low for longer than a whole character. The flags stay set until a status-read strobe clears them. The sampling enable comes from an external baud generator, and the block contains no transmitter.

Top module: `uart_os_rx`

## Requirements
- R1: After reset the status word is 0, `rx_avail` is 0 and `rd_data` is 0x00.
- R2: A character is one low start bit, 8 data bits with the least significant bit first, one parity bit and one high stop bit. Each bit lasts 16 `os_tick` pulses. A character received without a fault is returned unchanged through the read port.
- R3: A start is accepted only if the four samples taken at ticks 6, 7, 8 and 9 of the start bit are all low. A shorter low pulse produces no byte and sets no flag.
- R4: With the default even parity, the parity bit equals the XOR of the 8 data bits. A mismatch sets status bit 0, and the byte is still stored.
- R5: A low stop bit, or a data, parity or stop bit whose four samples disagree, sets status bit 1 and discards the byte.
- R6: The queue holds 16 bytes. A byte that completes while the queue is full sets status bit 2 and is dropped. The stored bytes are kept in arrival order.
- R7: When the line stays low for more than 176 sample ticks (one character), status bit 3 sets. A new character is only accepted after the line has returned high.
- R8: A cycle with `rd_en` high while data is available presents the oldest byte on `rd_data` one clock later. Otherwise `rd_data` holds its value, and `rd_en` on an empty queue is ignored.
- R9: Status flags are sticky. A one-cycle `stat_rd` pulse clears them, and an event in the same cycle as the clear keeps its flag set.
- R10: `rx_avail` is high exactly when the queue holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Sampling enable, 16 pulses per bit |
| rx_line | input | 1 | Serial input, idles high |
| rd_en | input | 1 | Pops the oldest byte |
| rd_data | output | 8 | Last popped byte |
| rx_avail | output | 1 | Queue is not empty |
| stat_rd | input | 1 | Clears the sticky status flags |
| status | output | 4 | {break, overrun, frame, parity} |

## Verification
The hardest case to reach is a bit whose four centre samples disagree. The stimulus holds one data bit at one level for its first half and switches it at mid-bit. Because of the synchronizer delay and the tick phase, the first sample always lands before the switch and the last sample always lands after it. The overrun case needs seventeen back-to-back characters with no reads in between; the bench then checks that the first sixteen come out in order. The break case holds the line low for thirteen bit times, which is past the 176-tick limit.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_e;

    localparam int FLAG_PE   = 0;
    localparam int FLAG_FE   = 1;
    localparam int FLAG_OE   = 2;
    localparam int FLAG_BE   = 3;
    localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import uart_os_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DATA_W  = 8,
    parameter bit PAR_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    output logic              hold_vld_o,
    output logic [DATA_W-1:0] hold_o,
    output logic              pe_evt_o,
    output logic              fe_evt_o,
    output logic              brk_evt_o
);
    localparam int FRAME_BITS  = DATA_W + 3;
    localparam int SR_W        = FRAME_BITS + 1;
    localparam int CNT_W       = $clog2(OS_RATE);
    localparam int BIDX_W      = $clog2(FRAME_BITS);
    localparam int FRAME_TICKS = FRAME_BITS * OS_RATE;
    localparam int LOW_W       = $clog2(FRAME_TICKS + 2);
    localparam int SMP_N       = 4;
    localparam int SMP_FIRST   = OS_RATE / 2 - 2;

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIDX_W-1:0] bidx;
        logic [SMP_N-1:0]  smp;
        logic [SR_W-1:0]   sr;
        logic              prev_rx;
        logic [LOW_W-1:0]  low_cnt;
        logic [DATA_W-1:0] hold;
        logic              hold_vld;
        logic              pe_evt;
        logic              fe_evt;
        logic              brk_evt;
    } dfr_t;

    dfr_t q, n;
    logic             in_win;
    logic             agree;
    logic             bitval;
    logic [SR_W-1:0]  sr_nx;
    logic             fe_nx;

    always_comb begin
        n          = q;
        n.hold_vld = 1'b0;
        n.pe_evt   = 1'b0;
        n.fe_evt   = 1'b0;
        n.brk_evt  = 1'b0;

        in_win = (q.cnt >= CNT_W'(SMP_FIRST)) && (q.cnt <= CNT_W'(SMP_FIRST + SMP_N - 1));
        agree  = (q.smp == '0) || (q.smp == '1);
        bitval = q.smp[SMP_N/2];
        sr_nx  = {q.sr[SR_W-1] | ~agree, bitval, q.sr[FRAME_BITS-1:1]};
        fe_nx  = ~sr_nx[FRAME_BITS-1] | sr_nx[SR_W-1] | sr_nx[0];

        // line-low run length for break detection
        if (tick) begin
            n.prev_rx = rx_s;
            if (rx_s) begin
                n.low_cnt = '0;
            end else if (q.low_cnt != LOW_W'(FRAME_TICKS + 1)) begin
                n.low_cnt = q.low_cnt + LOW_W'(1);
                if (q.low_cnt == LOW_W'(FRAME_TICKS)) n.brk_evt = 1'b1;
            end
        end

        case (q.st)
            RX_IDLE: begin
                if (tick && q.prev_rx && !rx_s) begin
                    n.st   = RX_RECV;
                    n.cnt  = CNT_W'(1);
                    n.bidx = '0;
                    n.smp  = '0;
                    n.sr   = '0;
                end
            end
            default: begin
                if (tick) begin
                    if (in_win) n.smp = {rx_s, q.smp[SMP_N-1:1]};
                    if (q.cnt == CNT_W'(OS_RATE - 1)) begin
                        n.cnt = '0;
                        n.smp = '0;
                        if (q.bidx == '0) begin
                            if (q.smp != '0) n.st = RX_IDLE;
                            else             n.bidx = BIDX_W'(1);
                        end else begin
                            n.sr = sr_nx;
                            if (q.bidx == BIDX_W'(FRAME_BITS - 1)) begin
                                n.st     = RX_IDLE;
                                n.fe_evt = fe_nx;
                                n.pe_evt = (^sr_nx[DATA_W:1]) ^ sr_nx[DATA_W+1] ^ PAR_ODD;
                                if (!fe_nx) begin
                                    n.hold     = sr_nx[DATA_W:1];
                                    n.hold_vld = 1'b1;
                                end
                            end else begin
                                n.bidx = q.bidx + BIDX_W'(1);
                            end
                        end
                    end else begin
                        n.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.prev_rx <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign hold_vld_o = q.hold_vld;
    assign hold_o     = q.hold;
    assign pe_evt_o   = q.pe_evt;
    assign fe_evt_o   = q.fe_evt;
    assign brk_evt_o  = q.brk_evt;

    // R5: a framing fault never releases a byte
    a_r5_fe_drops_byte: assert property (@(posedge clk) disable iff (!rst_n)
        q.fe_evt |-> !q.hold_vld);
    // R7: a break report only comes while the line is sampled low
    a_r7_break_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        q.brk_evt |-> !q.prev_rx);
    // R3: reception only begins after a low sample
    a_r3_start_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_RECV && $past(q.st) == RX_IDLE) |-> !q.prev_rx);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [AW-1:0]                wp;
        logic [AW-1:0]                rp;
        logic [CW-1:0]                cnt;
        logic [DATA_W-1:0]            rdat;
    } fifo_t;

    fifo_t q, n;
    logic  do_wr, do_rd;

    always_comb begin
        n     = q;
        do_wr = wr_en && (q.cnt != CW'(DEPTH));
        do_rd = rd_en && (q.cnt != '0);
        if (do_wr) begin
            n.mem[q.wp] = wr_data;
            n.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        end
        if (do_rd) begin
            n.rdat = q.mem[q.rp];
            n.rp   = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        end
        case ({do_wr, do_rd})
            2'b10:   n.cnt = q.cnt + CW'(1);
            2'b01:   n.cnt = q.cnt - CW'(1);
            default: n.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rd_data = q.rdat;
    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);

    // R6: the writer never pushes into a full queue
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R8: output only moves on a read
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R8: a read of an empty queue changes nothing
    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> ($stable(rd_data) && empty));
endmodule

// File: rtl/rx_status.sv
module rx_status #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] evt,
    input  logic          clr,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (clr ? '0 : flags_q) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    // R9: without a clear, no flag drops
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));
    // R9: an event during a clear survives
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == $past(evt)));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit PAR_ODD     = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rx_line,
    input  logic                 rd_en,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rx_avail,
    input  logic                 stat_rd,
    output logic [NUM_FLAGS-1:0] status
);
    logic              rx_s;
    logic              hold_vld;
    logic [DATA_W-1:0] hold;
    logic              pe_evt, fe_evt, brk_evt;
    logic              q_full, q_empty;
    logic              push;
    logic [NUM_FLAGS-1:0] evt;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    rx_deframer #(.OS_RATE(OS_RATE), .DATA_W(DATA_W), .PAR_ODD(PAR_ODD)) u_dfr (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s),
        .hold_vld_o(hold_vld), .hold_o(hold),
        .pe_evt_o(pe_evt), .fe_evt_o(fe_evt), .brk_evt_o(brk_evt)
    );

    always_comb begin
        push          = hold_vld && !q_full;
        evt           = '0;
        evt[FLAG_PE]  = pe_evt;
        evt[FLAG_FE]  = fe_evt;
        evt[FLAG_OE]  = hold_vld && q_full;
        evt[FLAG_BE]  = brk_evt;
    end

    rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(hold),
        .rd_en(rd_en), .rd_data(rd_data), .full(q_full), .empty(q_empty)
    );

    rx_status #(.NF(NUM_FLAGS)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(stat_rd), .flags(status)
    );

    assign rx_avail = !q_empty;

    // R6: a byte offered to a full queue raises the overrun flag
    a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && q_full) |=> status[FLAG_OE]);
    // R10: a stored byte makes data available on the next cycle
    a_r10_avail_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> rx_avail);
endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rx_avail;
    logic [3:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    uart_os_rx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .rd_en(rd_en), .rd_data(rd_data), .rx_avail(rx_avail),
        .stat_rd(stat_rd), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        rx_line = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input logic stop);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(b[i]);
        line_bit((^b) ^ bad_par);
        line_bit(stop);
        line_bit(1'b1);
        line_bit(1'b1);
    endtask

    task automatic read_expect(input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic clear_status(input string req);
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check(status == 4'h0, req, status, 0);
    endtask

    task automatic t_reset;
        check(status == 4'h0, "R1 status", status, 0);
        check(rx_avail == 1'b0, "R1 avail", rx_avail, 0);
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    endtask

    task automatic t_basic;
        send_frame(8'hA5, 1'b0, 1'b1);
        send_frame(8'h3C, 1'b0, 1'b1);
        check(rx_avail == 1'b1, "R10 avail after frames", rx_avail, 1);
        read_expect(8'hA5, "R2 first byte");
        read_expect(8'h3C, "R8 oldest next");
        check(rx_avail == 1'b0, "R10 avail drained", rx_avail, 0);
        check(status == 4'h0, "R2 clean status", status, 0);
    endtask

    task automatic t_empty_read;
        read_expect(8'h3C, "R8 empty read ignored");
        check(rx_avail == 1'b0, "R8 still empty", rx_avail, 0);
    endtask

    task automatic t_glitch;
        rx_line = 1'b0;
        repeat (16) @(negedge clk);
        line_bit(1'b1);
        line_bit(1'b1);
        line_bit(1'b1);
        check(rx_avail == 1'b0, "R3 glitch no byte", rx_avail, 0);
        check(status == 4'h0, "R3 glitch no flag", status, 0);
    endtask

    task automatic t_zero;
        send_frame(8'h00, 1'b0, 1'b1);
        check(status == 4'h0, "R7 full-zero frame no break", status, 0);
        read_expect(8'h00, "R2 zero byte");
    endtask

    task automatic t_parity;
        send_frame(8'h5A, 1'b1, 1'b1);
        check(status == 4'h1, "R4 parity flag", status, 1);
        send_frame(8'h11, 1'b0, 1'b1);
        check(status == 4'h1, "R9 flag sticky", status, 1);
        read_expect(8'h5A, "R4 byte kept");
        read_expect(8'h11, "R2 after parity");
        clear_status("R9 clear on read");
    endtask

    task automatic t_stop_bad;
        send_frame(8'h77, 1'b0, 1'b0);
        check(status == 4'h2, "R5 stop low flag", status, 2);
        check(rx_avail == 1'b0, "R5 byte dropped", rx_avail, 0);
        clear_status("R9 clear after frame fault");
    endtask

    task automatic t_disagree;
        logic [7:0] b;
        b = 8'h0F;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                rx_line = 1'b1;
                repeat (BIT_CLKS/2) @(negedge clk);
                rx_line = 1'b0;
                repeat (BIT_CLKS/2) @(negedge clk);
            end else begin
                line_bit(b[i]);
            end
        end
        line_bit(^b);
        line_bit(1'b1);
        line_bit(1'b1);
        line_bit(1'b1);
        check(status[1] == 1'b1, "R5 sample disagreement", status[1], 1);
        check(rx_avail == 1'b0, "R5 disagreement drops byte", rx_avail, 0);
        clear_status("R9 clear after disagreement");
    endtask

    task automatic t_break;
        rx_line = 1'b0;
        repeat (13 * BIT_CLKS) @(negedge clk);
        line_bit(1'b1);
        line_bit(1'b1);
        check(status == 4'hA, "R7 break and frame flags", status, 4'hA);
        check(rx_avail == 1'b0, "R7 no byte from break", rx_avail, 0);
        clear_status("R9 clear after break");
        send_frame(8'h42, 1'b0, 1'b1);
        read_expect(8'h42, "R7 receive after break");
        check(status == 4'h0, "R7 recovered status", status, 0);
    endtask

    task automatic t_overrun;
        for (int i = 0; i < 17; i++) send_frame(8'h80 + 8'(i), 1'b0, 1'b1);
        check(status == 4'h4, "R6 overrun flag", status, 4);
        for (int i = 0; i < 16; i++) read_expect(8'h80 + 8'(i), "R6 order kept");
        check(rx_avail == 1'b0, "R6 extra byte dropped", rx_avail, 0);
        clear_status("R9 clear after overrun");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic();
        t_empty_read();
        t_glitch();
        t_zero();
        t_parity();
        t_stop_bad();
        t_disagree();
        t_break();
        t_overrun();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule